// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces the timing for one horizontal line of an interline-transfer CCD. It runs from a master clock at a fixed multiple of the pixel rate. A line counter, together with a sub-pixel phase counter, drives every output:

- the line sync pulse;
- the two complementary horizontal shift phases;
- the reset-gate pulse;
- four mutually exclusive flags that mark which part of the readout is on the output: dummy cells, front black, image, rear black.

The current horizontal count is exported. Vertical-transfer logic uses it, together with a window flag and a grid strobe, to place its phase edges inside the horizontal blanking interval.

A line is 2280 pixel periods long. The readout occupies the last 1732 of them, in a fixed order: 28 dummy cells, 2 front black pixels, 1650 image pixels, then 52 rear black pixels. With default parameters it therefore starts at count 548. The blanking part before it holds a vertical-transfer schedule on a 40-count grid, from count 52 to count 332. During blanking the shift phases rest at a defined idle level. When enable is low, the counters freeze and all outputs go to their idle values. All lengths are elaboration parameters.

Top module: `ccd_hline_timer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `hcount` is 0. `hphase_a` is 1 and every other output is 0.
- R2: While `en` is high, the sub-pixel phase steps through 0..3 on each master clock. `hcount` advances by one each time the phase wraps from 3 to 0. `hcount` goes from 2279 back to 0.
- R3: While `en` is low, `hcount` and the sub-pixel phase hold their values. All outputs take the R1 values.
- R4: `hsync` is high exactly while `hcount` is below 8, with the block running.
- R5: When running, the flags follow the readout order. `reg_dummy` covers counts 548..575, `reg_black_front` covers 576..577, `reg_image` covers 578..2227 and `reg_black_rear` covers 2228..2279.
- R6: At most one region flag is high at any time. Exactly one is high whenever the running block is inside counts 548..2279.
- R7: Inside the readout, `hphase_a` is high in sub-phases 0 and 1 and low in 2 and 3. `hphase_b` is always its complement.
- R8: `rgate` is high only in sub-phase 0 of each readout pixel, so it pulses once per pixel.
- R9: Outside the readout, `hphase_a` is 1, `hphase_b` is 0 and `rgate` is 0.
- R10: `vt_win` is high for counts 52..332 while running. `vt_tick` is high for one master clock (sub-phase 0) at counts 52, 92, 132, 172, 212, 252, 292 and 332.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four cycles per pixel |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low freezes counters and idles outputs |
| hcount | output | 12 | Current horizontal count, 0..2279 |
| hsync | output | 1 | Line sync pulse at the start of the line |
| hphase_a | output | 1 | Horizontal shift phase A, idle high |
| hphase_b | output | 1 | Horizontal shift phase B, complement of A |
| rgate | output | 1 | Reset-gate pulse, once per readout pixel |
| reg_dummy | output | 1 | Dummy (pre-scan) cell on output |
| reg_black_front | output | 1 | Front optical-black pixel on output |
| reg_image | output | 1 | Active image pixel on output |
| reg_black_rear | output | 1 | Rear optical-black pixel on output |
| vt_win | output | 1 | Vertical-transfer window inside blanking |
| vt_tick | output | 1 | One-clock strobe on each 40-count grid point |

## Verification
A corrupted line counter shows on `hcount` in the same cycle. It then also shows on the flag, sync and window outputs, because they decode that counter. A slipped sub-phase shows within one pixel (four clocks) as a phase pattern or reset-gate pulse out of step. A wrong wrap, region boundary or grid point shows only at that count. For this reason the stimulus covers two full lines, pauses inside the readout and inside the transfer window, and a reset in the middle of a line.

// File: rtl/ccd_hline_pkg.sv
// Shared types for the horizontal line timing generator.
// Assumes: one readout region is active at a time; BLANK covers the rest.
package ccd_hline_pkg;
    typedef enum logic [2:0] {
        SEG_BLANK = 3'd0,
        SEG_DUMMY = 3'd1,
        SEG_BFRNT = 3'd2,
        SEG_IMAGE = 3'd3,
        SEG_BREAR = 3'd4
    } seg_e;
endpackage

// File: rtl/ccd_hline_count.sv
// Line and sub-pixel counters.
// Assumes: SUB >= 2 master clocks per pixel; LINE_LEN >= 2.
// live is low in reset and goes high one clock after reset is released.
module ccd_hline_count #(
    parameter int LINE_LEN = 2280,
    parameter int SUB      = 4,
    localparam int CNT_W   = $clog2(LINE_LEN),
    localparam int SUB_W   = $clog2(SUB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] hcnt,
    output logic [SUB_W-1:0] sub,
    output logic             live
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_LEN - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB - 1);

    // Step the sub-pixel phase; advance and wrap the line count on its wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            sub  <= '0;
            live <= 1'b0;
        end else begin
            live <= 1'b1;
            if (en) begin
                if (sub == SUB_LAST) begin
                    sub  <= '0;
                    hcnt <= (hcnt == CNT_LAST) ? '0 : hcnt + CNT_W'(1);
                end else begin
                    sub <= sub + SUB_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ccd_hline_region.sv
// Decodes the line count into the readout segment and the vertical-transfer
// window and grid hits.
// Assumes: the readout ends at the last count of the line, and the transfer
// grid ends before the readout starts.
module ccd_hline_region
    import ccd_hline_pkg::*;
#(
    parameter int LINE_LEN = 2280,
    parameter int N_DUMMY  = 28,
    parameter int N_BFRNT  = 2,
    parameter int N_IMAGE  = 1650,
    parameter int N_BREAR  = 52,
    parameter int VT_FIRST = 52,
    parameter int VT_STEP  = 40,
    parameter int VT_N     = 8,
    localparam int CNT_W   = $clog2(LINE_LEN)
) (
    input  logic [CNT_W-1:0] hcnt,
    output seg_e             seg,
    output logic             in_vt,
    output logic             on_grid
);
    localparam int RD_LEN  = N_DUMMY + N_BFRNT + N_IMAGE + N_BREAR;
    localparam int RD_POS  = LINE_LEN - RD_LEN;
    localparam int VT_END  = VT_FIRST + (VT_N - 1) * VT_STEP;
    localparam logic [CNT_W-1:0] B_DUMMY = CNT_W'(RD_POS);
    localparam logic [CNT_W-1:0] B_BFRNT = CNT_W'(RD_POS + N_DUMMY);
    localparam logic [CNT_W-1:0] B_IMAGE = CNT_W'(RD_POS + N_DUMMY + N_BFRNT);
    localparam logic [CNT_W-1:0] B_BREAR = CNT_W'(RD_POS + N_DUMMY + N_BFRNT + N_IMAGE);
    localparam logic [CNT_W-1:0] V_LO    = CNT_W'(VT_FIRST);
    localparam logic [CNT_W-1:0] V_HI    = CNT_W'(VT_END);

    initial begin
        if (RD_POS <= VT_END) $error("transfer grid overlaps the readout");
    end

    // Pick the segment from fixed boundaries in readout order.
    always_comb begin
        if (hcnt >= B_BREAR)      seg = SEG_BREAR;
        else if (hcnt >= B_IMAGE) seg = SEG_IMAGE;
        else if (hcnt >= B_BFRNT) seg = SEG_BFRNT;
        else if (hcnt >= B_DUMMY) seg = SEG_DUMMY;
        else                      seg = SEG_BLANK;
    end

    // Transfer window spans the first to the last grid point.
    always_comb in_vt = (hcnt >= V_LO) && (hcnt <= V_HI);

    logic [VT_N-1:0] hit;
    for (genvar gi = 0; gi < VT_N; gi++) begin : g_grid
        localparam logic [CNT_W-1:0] PT = CNT_W'(VT_FIRST + gi * VT_STEP);
        // Match one grid point.
        always_comb hit[gi] = (hcnt == PT);
    end

    // Any grid point reached.
    always_comb on_grid = |hit;
endmodule

// File: rtl/ccd_hline_phase.sv
// Makes the two horizontal shift phases and the reset-gate pulse from the
// sub-pixel phase.
// Assumes: RG_W <= SUB/2, so the reset gate sits inside the phase-A-high half.
module ccd_hline_phase #(
    parameter int   SUB     = 4,
    parameter int   RG_W    = 1,
    parameter logic IDLE_A  = 1'b1,
    localparam int  SUB_W   = $clog2(SUB)
) (
    input  logic [SUB_W-1:0] sub,
    input  logic             shifting,
    output logic             ph_a,
    output logic             ph_b,
    output logic             rg
);
    localparam logic [SUB_W-1:0] HALF   = SUB_W'(SUB / 2);
    localparam logic [SUB_W-1:0] RG_END = SUB_W'(RG_W);

    // Phase A high in the first half of a pixel while shifting, idle otherwise.
    always_comb begin
        ph_a = shifting ? (sub < HALF) : IDLE_A;
        ph_b = ~ph_a;
    end

    // Reset gate at the start of each shifted pixel.
    always_comb rg = shifting && (sub < RG_END);
endmodule

// File: rtl/ccd_hline_timer.sv
// Top of the horizontal line timing generator.
// Assumes: clk is SUB times the pixel rate; reset is synchronous, active low.
// Outputs are decoded from the counters and idle while not running.
module ccd_hline_timer
    import ccd_hline_pkg::*;
#(
    parameter int   LINE_LEN = 2280,
    parameter int   SUB      = 4,
    parameter int   SYNC_W   = 8,
    parameter int   N_DUMMY  = 28,
    parameter int   N_BFRNT  = 2,
    parameter int   N_IMAGE  = 1650,
    parameter int   N_BREAR  = 52,
    parameter int   VT_FIRST = 52,
    parameter int   VT_STEP  = 40,
    parameter int   VT_N     = 8,
    parameter int   RG_W     = 1,
    parameter logic IDLE_A   = 1'b1,
    localparam int  CNT_W    = $clog2(LINE_LEN),
    localparam int  SUB_W    = $clog2(SUB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] hcount,
    output logic             hsync,
    output logic             hphase_a,
    output logic             hphase_b,
    output logic             rgate,
    output logic             reg_dummy,
    output logic             reg_black_front,
    output logic             reg_image,
    output logic             reg_black_rear,
    output logic             vt_win,
    output logic             vt_tick
);
    localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_W);

    logic [CNT_W-1:0] hcnt_q;
    logic [SUB_W-1:0] sub_q;
    logic             live_q;
    logic             go;
    seg_e             seg;
    logic             in_vt;
    logic             on_grid;

    ccd_hline_count #(.LINE_LEN(LINE_LEN), .SUB(SUB)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en),
        .hcnt(hcnt_q), .sub(sub_q), .live(live_q)
    );

    ccd_hline_region #(
        .LINE_LEN(LINE_LEN), .N_DUMMY(N_DUMMY), .N_BFRNT(N_BFRNT),
        .N_IMAGE(N_IMAGE), .N_BREAR(N_BREAR),
        .VT_FIRST(VT_FIRST), .VT_STEP(VT_STEP), .VT_N(VT_N)
    ) u_seg (
        .hcnt(hcnt_q), .seg(seg), .in_vt(in_vt), .on_grid(on_grid)
    );

    ccd_hline_phase #(.SUB(SUB), .RG_W(RG_W), .IDLE_A(IDLE_A)) u_ph (
        .sub(sub_q), .shifting(go && (seg != SEG_BLANK)),
        .ph_a(hphase_a), .ph_b(hphase_b), .rg(rgate)
    );

    // Outputs are live only after reset and while enabled.
    always_comb go = live_q && en;

    // Sync, region flags and transfer strobes, gated by run state.
    always_comb begin
        hcount          = hcnt_q;
        hsync           = go && (hcnt_q < SYNC_END);
        reg_dummy       = go && (seg == SEG_DUMMY);
        reg_black_front = go && (seg == SEG_BFRNT);
        reg_image       = go && (seg == SEG_IMAGE);
        reg_black_rear  = go && (seg == SEG_BREAR);
        vt_win          = go && in_vt;
        vt_tick         = go && on_grid && (sub_q == '0);
    end
endmodule

// File: rtl/ccd_hline_chk.sv
// Property checker for ccd_hline_timer, attached by bind below.
module ccd_hline_chk #(
    parameter int   LINE_LEN = 2280,
    parameter int   SUB      = 4,
    parameter int   SYNC_W   = 8,
    parameter int   RD_POS   = 548,
    parameter logic IDLE_A   = 1'b1,
    localparam int  CNT_W    = $clog2(LINE_LEN),
    localparam int  SUB_W    = $clog2(SUB)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] hcount,
    input logic [SUB_W-1:0] sub,
    input logic             hsync,
    input logic             hphase_a,
    input logic             hphase_b,
    input logic             rgate,
    input logic [3:0]       flags,
    input logic             vt_win
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_LEN - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB - 1);
    localparam logic [CNT_W-1:0] RD_B     = CNT_W'(RD_POS);
    localparam logic [CNT_W-1:0] SYNC_B   = CNT_W'(SYNC_W);

    logic [CNT_W-1:0] nxt;
    // Count the line should reach after the next pixel wrap.
    always_comb nxt = (hcount == CNT_LAST) ? '0 : hcount + CNT_W'(1);

    p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sub == SUB_LAST) |=> (hcount == $past(nxt)));
    p_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sub != SUB_LAST) |=> $stable(hcount));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(hcount) && $stable(sub)));
    p_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> (hcount < SYNC_B));
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));
    p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hcount >= RD_B) |-> ($countones(flags) == 1));
    p_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags) |-> (hphase_a != hphase_b));
    p_rg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rgate |-> ((|flags) && hphase_a != IDLE_A || (|flags) && hphase_a));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|flags) |-> (hphase_a == IDLE_A && hphase_b != IDLE_A && !rgate));
    p_vt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vt_win |-> !(|flags));
endmodule

bind ccd_hline_timer ccd_hline_chk #(
    .LINE_LEN(LINE_LEN), .SUB(SUB), .SYNC_W(SYNC_W),
    .RD_POS(LINE_LEN - N_DUMMY - N_BFRNT - N_IMAGE - N_BREAR),
    .IDLE_A(IDLE_A)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .hcount(hcount), .sub(sub_q),
    .hsync(hsync), .hphase_a(hphase_a), .hphase_b(hphase_b), .rgate(rgate),
    .flags({reg_dummy, reg_black_front, reg_image, reg_black_rear}),
    .vt_win(vt_win)
);

// File: tb/tb_ccd_hline_timer.sv
module tb_ccd_hline_timer;
    localparam int LAST = 2279;
    localparam int RD0 = 548, BF0 = 576, IM0 = 578, BR0 = 2228;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [11:0] hcount;
    logic hsync, hphase_a, hphase_b, rgate;
    logic reg_dummy, reg_black_front, reg_image, reg_black_rear, vt_win, vt_tick;

    ccd_hline_timer dut (
        .clk(clk), .rst_n(rst_n), .en(en), .hcount(hcount), .hsync(hsync),
        .hphase_a(hphase_a), .hphase_b(hphase_b), .rgate(rgate),
        .reg_dummy(reg_dummy), .reg_black_front(reg_black_front),
        .reg_image(reg_image), .reg_black_rear(reg_black_rear),
        .vt_win(vt_win), .vt_tick(vt_tick)
    );

    always #10 clk = ~clk;

    typedef struct {
        int  hc;
        bit  live, go, sync, pa, pb, rg, vw, vt;
        bit  [3:0] fl;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    int mh = 0, ms = 0;
    bit live = 0, prev_r = 0, prev_e = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Driver: advance the reference model at each edge, then drive and push.
    task automatic step(input bit r, input bit e);
        exp_t x;
        bit rd;
        @(posedge clk);
        if (!prev_r) begin
            mh = 0; ms = 0; live = 0;
        end else begin
            live = 1;
            if (prev_e) begin
                if (ms == 3) begin ms = 0; mh = (mh == LAST) ? 0 : mh + 1; end
                else ms++;
            end
        end
        #1;
        rst_n = r; en = e; prev_r = r; prev_e = e;
        x.hc = mh; x.live = live; x.go = live && e;
        rd = x.go && mh >= RD0;
        x.sync = x.go && mh < 8;
        x.fl = {x.go && mh >= RD0 && mh < BF0, x.go && mh >= BF0 && mh < IM0,
                x.go && mh >= IM0 && mh < BR0, x.go && mh >= BR0};
        x.pa = rd ? (ms < 2) : 1'b1;
        x.pb = ~x.pa;
        x.rg = rd && ms == 0;
        x.vw = x.go && mh >= 52 && mh <= 332;
        x.vt = x.vw && ms == 0 && ((mh - 52) % 40 == 0);
        q.push_back(x);
    endtask

    task automatic run(input bit r, input bit e, input int n);
        for (int i = 0; i < n; i++) step(r, e);
    endtask

    // Monitor: compare each expected item with the ports between edges.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t x;
                string ctx;
                bit rd;
                x = q.pop_front();
                ctx = !x.live ? "R1" : (!x.go ? "R3" : "");
                rd = x.go && x.hc >= RD0;
                chk(int'(hcount) == x.hc, ctx == "" ? "R2" : ctx, "hcount", int'(hcount), x.hc);
                chk(hsync == x.sync, ctx == "" ? "R4" : ctx, "hsync", hsync, x.sync);
                chk({reg_dummy, reg_black_front, reg_image, reg_black_rear} == x.fl,
                    ctx == "" ? "R5" : ctx, "flags",
                    {reg_dummy, reg_black_front, reg_image, reg_black_rear}, x.fl);
                if (rd)
                    chk($countones({reg_dummy, reg_black_front, reg_image, reg_black_rear}) == 1,
                        "R6", "flag count",
                        $countones({reg_dummy, reg_black_front, reg_image, reg_black_rear}), 1);
                chk(hphase_a == x.pa && hphase_b == x.pb,
                    ctx != "" ? ctx : (rd ? "R7" : "R9"), "phases",
                    {hphase_a, hphase_b}, {x.pa, x.pb});
                chk(rgate == x.rg, ctx != "" ? ctx : (rd ? "R8" : "R9"), "rgate", rgate, x.rg);
                chk(vt_win == x.vw && vt_tick == x.vt, ctx == "" ? "R10" : ctx, "vt",
                    {vt_win, vt_tick}, {x.vw, x.vt});
            end
        end
    end

    // Stimulus: reset, full lines, pauses in readout and window, mid-line reset.
    initial begin
        run(0, 1, 3);        // R1 with enable high during reset
        run(1, 1, 4200);     // R2 R4 R5 R7 R8 R10 through readout start
        run(1, 0, 40);       // R3 pause inside image region
        run(1, 1, 5160);     // across the 2279 -> 0 wrap into transfer window
        run(1, 0, 30);       // R3 pause inside the window
        run(1, 1, 9500);
        run(0, 1, 2);        // R1 reset in mid-line
        run(1, 1, 3000);
        @(posedge clk);
        #15;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule